// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Width Detection

This block moves 8-bit voice samples over a serial PCM link clocked from outside. An external bit clock and an 8 kHz frame sync arrive as plain pins. Both are oversampled on a faster system clock. The block measures each frame sync pulse by counting the bit-clock falling edges seen while the sync is high. That measurement picks long or short framing for the following frame.

In short framing, transmit data begins one rising edge after the falling edge that saw the sync, and receive capture begins one falling edge later. In long framing, the most significant bit is placed on the line as soon as the sync rises. The transmit line is released at the falling edge inside the last bit. Long framing keeps the line driven for as long as the sync stays high.

A power-down input silences the port. After it is released, the output stays off for two further frames. The parallel transmit word is taken at the start of each frame. Each received word is presented with a one-cycle strobe.

Top module: `pcm_sync_port`

## Requirements
- R1: After reset, `dout_oe_o` and `rx_valid_o` are 0, `rx_word_o` is 0 and `long_mode_o` is 0 (short framing).
- R2: A sync pulse that is high across two or more bit-clock falling edges sets `long_mode_o` to 1. A pulse high across exactly one falling edge sets it to 0. The new value appears after the sync falls and governs the next frame.
- R3: In short framing, the MSB of the transmit word is driven on the first bit-clock rising edge after the falling edge that saw sync high. Each following rising edge drives the next lower bit.
- R4: In long framing, the MSB is driven from the sync rising edge. Each later bit-clock rising edge drives the next lower bit.
- R5: `dout_oe_o` drops at the bit-clock falling edge in the middle of the LSB, unless R6 holds it.
- R6: In long framing, `dout_oe_o` stays 1 while the sync is high, even after the LSB has ended.
- R7: In short framing, the receiver samples `din_i` on the eight falling edges that follow the falling edge coinciding with sync. The first sample is the MSB.
- R8: In long framing, the receiver samples `din_i` on the eight falling edges starting with the first one after the sync rise. The first sample is the MSB.
- R9: Each completed word appears on `rx_word_o` with `rx_valid_o` high for exactly one system-clock cycle.
- R10: While `pdn_i` is 1, `dout_oe_o` is 0 and no word is received.
- R11: After `pdn_i` falls, the output stays undriven through the next two frames. Transmission resumes in the third frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync, rising edge once per frame |
| din_i | input | 1 | Serial receive data |
| pdn_i | input | 1 | Power-down request, synchronous to clk |
| tx_word_i | input | 8 | Parallel word to send, taken at frame start |
| dout_o | output | 1 | Serial transmit data |
| dout_oe_o | output | 1 | Drive enable for the tri-state data pad |
| rx_word_o | output | 8 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |
| long_mode_o | output | 1 | 1 when the next frame uses long framing |

## Verification
A pin edge becomes an internal event two system clocks after it happens. Transmit data and the drive enable then change one clock later, and the receive strobe also comes one clock after the capturing event. All of these land within four system clocks of the bit-clock edge. Each bit time lasts 50 system clocks, so the bench samples each serial result at the opposite bit-clock edge, half a bit after the edge that caused it. The framing mode is read after the frame has ended. Received words are compared whenever the strobe shows, against a queue that the frame driver fills.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  localparam int unsigned LONG_FALLS = 2;

endpackage

// File: rtl/pcm_sync_chain.sv
module pcm_sync_chain #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign lvl_o[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl #(
  parameter int unsigned PDN_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_i,
  input  logic fs_lvl_i,
  input  logic fs_rise_i,
  input  logic fs_fall_i,
  input  logic bc_fall_i,
  output logic long_mode_o,
  output logic start_long_o,
  output logic start_short_o,
  output logic tx_ok_o
);
  import pcm_port_pkg::*;

  localparam int unsigned SKIP_W = $clog2(PDN_FRAMES + 1);
  localparam int unsigned HI_W   = $clog2(LONG_FALLS + 1);
  localparam logic [HI_W-1:0]   HI_SAT   = HI_W'(LONG_FALLS);
  localparam logic [SKIP_W-1:0] SKIP_INI = SKIP_W'(PDN_FRAMES);

  logic [HI_W-1:0]   hi_cnt_q, hi_cnt_d;
  logic              long_q, long_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic              frame_ok_q, frame_ok_d;
  logic              started_q, started_d;
  logic              skip_zero;

  always_comb begin
    skip_zero     = (skip_q == '0);
    tx_ok_o       = !pdn_i && (fs_rise_i ? skip_zero : frame_ok_q);
    start_long_o  = !pdn_i && fs_rise_i && long_q;
    start_short_o = !pdn_i && bc_fall_i && fs_lvl_i && !long_q && !started_q;
    long_mode_o   = long_q;
  end

  always_comb begin
    hi_cnt_d   = hi_cnt_q;
    long_d     = long_q;
    skip_d     = skip_q;
    frame_ok_d = frame_ok_q;
    started_d  = started_q;

    if (fs_rise_i) begin
      hi_cnt_d = '0;
    end else if (bc_fall_i && fs_lvl_i && (hi_cnt_q != HI_SAT)) begin
      hi_cnt_d = hi_cnt_q + HI_W'(1);
    end

    if (fs_fall_i) begin
      long_d = (hi_cnt_q == HI_SAT);
    end

    if (pdn_i) begin
      skip_d     = SKIP_INI;
      frame_ok_d = 1'b0;
    end else if (fs_rise_i) begin
      frame_ok_d = skip_zero;
      if (!skip_zero) begin
        skip_d = skip_q - SKIP_W'(1);
      end
    end

    if (start_long_o || start_short_o) begin
      started_d = 1'b1;
    end else if (fs_rise_i) begin
      started_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q   <= '0;
      long_q     <= 1'b0;
      skip_q     <= '0;
      frame_ok_q <= 1'b0;
      started_q  <= 1'b0;
    end else begin
      hi_cnt_q   <= hi_cnt_d;
      long_q     <= long_d;
      skip_q     <= skip_d;
      frame_ok_q <= frame_ok_d;
      started_q  <= started_d;
    end
  end

endmodule

// File: rtl/pcm_tx.sv
module pcm_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         start_long_i,
  input  logic         start_short_i,
  input  logic         bc_rise_i,
  input  logic         bc_fall_i,
  input  logic         hold_i,
  input  logic         ok_i,
  input  logic [W-1:0] word_i,
  output logic         dout_o,
  output logic         oe_o
);
  import pcm_port_pkg::*;

  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  tx_state_e     state_q, state_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      state_d = TX_IDLE;
    end else if (start_long_i) begin
      state_d = TX_SHIFT;
      sh_d    = word_i;
      cnt_d   = '0;
    end else if (start_short_i) begin
      state_d = TX_WAIT;
    end else begin
      unique case (state_q)
        TX_WAIT: begin
          if (bc_rise_i) begin
            state_d = TX_SHIFT;
            sh_d    = word_i;
            cnt_d   = '0;
          end
        end
        TX_SHIFT: begin
          if (bc_rise_i && (cnt_q != LAST)) begin
            sh_d  = {sh_q[W-2:0], 1'b0};
            cnt_d = cnt_q + CW'(1);
          end else if (bc_fall_i && (cnt_q == LAST)) begin
            state_d = TX_IDLE;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dout_o = sh_q[W-1];
  assign oe_o   = ok_i && ((state_q == TX_SHIFT) || hold_i);

endmodule

// File: rtl/pcm_rx.sv
module pcm_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic         bc_fall_i,
  input  logic         din_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);

  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [W-1:0]  word_q, word_d;
  logic          valid_q, valid_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    word_d   = word_q;
    valid_d  = 1'b0;
    if (clr_i) begin
      active_d = 1'b0;
    end else if (start_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && bc_fall_i) begin
      sh_d  = {sh_q[W-2:0], din_i};
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        word_d   = sh_d;
        valid_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      word_q   <= word_d;
      valid_q  <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/pcm_sync_port.sv
module pcm_sync_port #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PDN_FRAMES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              din_i,
  input  logic              pdn_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              long_mode_o
);

  localparam int unsigned PIN_N  = 3;
  localparam int unsigned IX_BC  = 0;
  localparam int unsigned IX_FS  = 1;
  localparam int unsigned IX_DIN = 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [PIN_N-1:0] pin_lvl;
  logic             bc_prev_q, fs_prev_q;
  logic             bc_rise, bc_fall, fs_rise, fs_fall;
  logic             start_long, start_short, tx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  pcm_sync_chain #(.N(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({din_i, fsync_i, bclk_i}),
    .lvl_o   (pin_lvl)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bc_prev_q <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      bc_prev_q <= pin_lvl[IX_BC];
      fs_prev_q <= pin_lvl[IX_FS];
    end
  end

  assign bc_rise = pin_lvl[IX_BC] & ~bc_prev_q;
  assign bc_fall = ~pin_lvl[IX_BC] & bc_prev_q;
  assign fs_rise = pin_lvl[IX_FS] & ~fs_prev_q;
  assign fs_fall = ~pin_lvl[IX_FS] & fs_prev_q;

  pcm_frame_ctl #(.PDN_FRAMES(PDN_FRAMES)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .pdn_i         (pdn_i),
    .fs_lvl_i      (pin_lvl[IX_FS]),
    .fs_rise_i     (fs_rise),
    .fs_fall_i     (fs_fall),
    .bc_fall_i     (bc_fall),
    .long_mode_o   (long_mode_o),
    .start_long_o  (start_long),
    .start_short_o (start_short),
    .tx_ok_o       (tx_ok)
  );

  pcm_tx #(.W(WORD_W)) u_tx (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .clr_i         (pdn_i),
    .start_long_i  (start_long & tx_ok),
    .start_short_i (start_short & tx_ok),
    .bc_rise_i     (bc_rise),
    .bc_fall_i     (bc_fall),
    .hold_i        (long_mode_o & pin_lvl[IX_FS]),
    .ok_i          (tx_ok),
    .word_i        (tx_word_i),
    .dout_o        (dout_o),
    .oe_o          (dout_oe_o)
  );

  pcm_rx #(.W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (pdn_i),
    .start_i   (start_long | start_short),
    .bc_fall_i (bc_fall),
    .din_i     (pin_lvl[IX_DIN]),
    .word_o    (rx_word_o),
    .valid_o   (rx_valid_o)
  );

endmodule

// File: rtl/pcm_sync_port_chk.sv
module pcm_sync_port_chk #(
  parameter int unsigned PDN_FRAMES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic pdn_i,
  input logic dout_o,
  input logic dout_oe_o,
  input logic rx_valid_o,
  input logic long_mode_o,
  input logic bc_rise,
  input logic bc_fall,
  input logic fs_rise,
  input logic fs_fall
);

  localparam int unsigned RW = $clog2(PDN_FRAMES + 2);
  localparam logic [RW-1:0] RSAT = RW'(PDN_FRAMES + 1);

  logic [RW-1:0] rises_q;
  logic          pd_seen_q;
  logic [RW:0]   rises_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q   <= '0;
      pd_seen_q <= 1'b0;
    end else if (pdn_i) begin
      rises_q   <= '0;
      pd_seen_q <= 1'b1;
    end else if (fs_rise && (rises_q != RSAT)) begin
      rises_q <= rises_q + RW'(1);
    end
  end

  assign rises_now = {1'b0, rises_q} + (RW+1)'(fs_rise);

  // R9: strobe lasts one cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R10: nothing is driven or received during power-down
  a_r10_pdn_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_i |-> !dout_oe_o);
  a_r10_pdn_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_i |=> !rx_valid_o);

  // R2: framing mode only moves after a sync falling edge
  a_r2_mode_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_mode_o) |-> $past(fs_fall));

  // R3 / R4: driven data only moves after a bit-clock rise or sync rise
  a_r3_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe_o && $past(dout_oe_o) && !$stable(dout_o)) |-> $past(bc_rise || fs_rise));

  // R5 / R6: release only at a bit-clock fall, a sync fall or power-down
  a_r5_release_point: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe_o) |-> ($past(bc_fall) || fs_fall || pdn_i));

  // R11: after power-down, driving waits for the third sync rise
  a_r11_quiet_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe_o && pd_seen_q) |-> (rises_now > (RW+1)'(PDN_FRAMES)));

endmodule

bind pcm_sync_port pcm_sync_port_chk #(.PDN_FRAMES(PDN_FRAMES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pdn_i       (pdn_i),
  .dout_o      (dout_o),
  .dout_oe_o   (dout_oe_o),
  .rx_valid_o  (rx_valid_o),
  .long_mode_o (long_mode_o),
  .bc_rise     (bc_rise),
  .bc_fall     (bc_fall),
  .fs_rise     (fs_rise),
  .fs_fall     (fs_fall)
);

// File: tb/pcm_sync_port_test.sv
`timescale 1ns/1ps
module pcm_sync_port_test;

  localparam int HALF = 125;
  localparam int BITS = 16;

  logic       clk;
  logic       rst_n;
  logic       bclk_i, fsync_i, din_i, pdn_i;
  logic [7:0] tx_word_i;
  logic       dout_o, dout_oe_o, rx_valid_o, long_mode_o;
  logic [7:0] rx_word_o;

  int  checks;
  int  errors;
  int  cycles;
  bit  done;
  bit  mode_exp;
  int  quiet_left;
  bit  prev_valid;
  logic [8:0] rxq[$];

  pcm_sync_port uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_i      (bclk_i),
    .fsync_i     (fsync_i),
    .din_i       (din_i),
    .pdn_i       (pdn_i),
    .tx_word_i   (tx_word_i),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o),
    .rx_word_o   (rx_word_o),
    .rx_valid_o  (rx_valid_o),
    .long_mode_o (long_mode_o)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected receive words as strobes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid_o && prev_valid) begin
        check(1'b0, "R9 strobe longer than one cycle", 32'd1, 32'd0);
      end
      if (rx_valid_o && !prev_valid) begin
        if (rxq.size() == 0) begin
          check(1'b0, "R10 unexpected received word", {24'd0, rx_word_o}, 32'd0);
        end else begin
          logic [8:0] item;
          item = rxq.pop_front();
          check(rx_word_o === item[7:0], item[8] ? "R8 long receive" : "R7 short receive",
                {24'd0, rx_word_o}, {24'd0, item[7:0]});
        end
      end
      prev_valid = rx_valid_o;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog on all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // driver: one frame of BITS bit periods, sync rising with the first bit-clock rise
  task automatic run_frame(input int fs_bits, input logic [7:0] txw, input logic [7:0] rxw);
    bit lm;
    int off;
    bit txen;
    lm   = mode_exp;
    off  = lm ? 0 : 1;
    txen = !pdn_i && (quiet_left == 0);
    tx_word_i = txw;
    if (!pdn_i) rxq.push_back({lm, rxw});
    for (int b = 0; b < BITS; b++) begin
      int k;
      bit exp_oe;
      string tag;
      k = b - off;
      bclk_i  = 1'b1;
      fsync_i = (b < fs_bits);
      din_i   = (k >= 0 && k < 8) ? rxw[7-k] : 1'b0;
      #HALF;
      exp_oe = txen && ((k >= 0 && k < 8) || (lm && b < fs_bits));
      if (pdn_i)               tag = "R10 drive enable";
      else if (quiet_left > 0) tag = "R11 drive enable";
      else if (k == 8)         tag = "R5 drive enable";
      else if (k > 8)          tag = "R6 drive enable";
      else if (lm)             tag = "R4 drive enable";
      else                     tag = "R3 drive enable";
      check(dout_oe_o === exp_oe, tag, {31'd0, dout_oe_o}, {31'd0, exp_oe});
      if (exp_oe && k >= 0 && k < 8) begin
        check(dout_o === txw[7-k], lm ? "R4 data bit" : "R3 data bit",
              {31'd0, dout_o}, {31'd0, txw[7-k]});
      end
      bclk_i = 1'b0;
      #HALF;
    end
    mode_exp = (fs_bits >= 2);
    check(long_mode_o === mode_exp, "R2 framing mode", {31'd0, long_mode_o}, {31'd0, mode_exp});
    if (!pdn_i && quiet_left > 0) quiet_left--;
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    mode_exp = 1'b0; quiet_left = 0; prev_valid = 1'b0;
    rst_n = 1'b0; bclk_i = 1'b0; fsync_i = 1'b0; din_i = 1'b0;
    pdn_i = 1'b0; tx_word_i = 8'h00;
    #100;
    rst_n = 1'b1;
    #50;
    check(dout_oe_o === 1'b0,   "R1 drive enable", {31'd0, dout_oe_o}, 32'd0);
    check(rx_valid_o === 1'b0,  "R1 strobe", {31'd0, rx_valid_o}, 32'd0);
    check(rx_word_o === 8'h00,  "R1 word", {24'd0, rx_word_o}, 32'd0);
    check(long_mode_o === 1'b0, "R1 mode", {31'd0, long_mode_o}, 32'd0);

    run_frame(1,  8'hA5, 8'h3C);   // short pulse, short framing
    run_frame(3,  8'h96, 8'hC3);   // long pulse, still short framing
    run_frame(2,  8'h81, 8'h7E);   // long framing
    run_frame(11, 8'h5A, 8'h01);   // long framing, sync held past the LSB
    run_frame(1,  8'hFF, 8'h80);   // long framing, short pulse
    run_frame(1,  8'h00, 8'hFF);   // back to short framing
    pdn_i = 1'b1;
    quiet_left = 2;
    run_frame(1,  8'h55, 8'hAA);   // powered down
    pdn_i = 1'b0;
    run_frame(1,  8'h69, 8'h96);   // quiet frame 1
    run_frame(2,  8'h24, 8'h42);   // quiet frame 2
    run_frame(4,  8'h3C, 8'hE7);   // transmitting again, long framing
    run_frame(1,  8'hC6, 8'h6C);   // long framing, short pulse
    run_frame(1,  8'h1B, 8'hB1);   // short framing

    #200;
    check(rxq.size() == 0, "R9 every word strobed", rxq.size(), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule